// File: doc/BRIEF.md
# Masked Level Interrupt Hub with Cascaded Sub-Bus Flags

The hub gathers sixteen level-sensitive interrupt sources into a single CPU interrupt line. Each source has one bit in a pending-status register. The bit follows its source one clock later, and software can knock it down by writing a 1 to that position. An enable register decides which pending bits may raise the CPU line. This register is not loaded on a write: each written 1 flips the matching enable bit, so software changes only the bits it names, without reading the register first.

A small secondary flag register collects two sub-bus sources at sparse bit positions. Whenever any of its flags is set, primary line 1 is driven, alongside the primary input of that line. Software clears these flags by writing 1s, in the same way as the primary status.

The register port is a plain, single-cycle strobe interface. A write takes effect at the clock edge where `wr_en` is high. Read data is a combinational view of the register that `addr` selects, and a read has no side effect. The interface has no back-pressure, because every access completes at once.

Top module: `irq_hub`

## Requirements
- R1: After reset the status, enable and sub-bus flag registers all read 0, and `irq` is low.
- R2: Status bit i reads 1 one cycle after source i is sampled high. It reads 0 one cycle after the source is sampled low.
- R3: A write to offset 0x000 clears every status bit written as 1 and leaves bits written as 0 following their sources. Reading any register changes no state.
- R4: If a source is still high in the cycle its status bit is cleared by a write, the bit reads 0 for one cycle and then reads 1 again.
- R5: A write to offset 0x010 inverts each enable bit whose written bit is 1 and keeps the others. With no write the enable register holds its value.
- R6: `irq` is high exactly when at least one bit is set in both the status and enable registers, and it changes in the same cycle as those registers.
- R7: Sub-bus source k sets flag bit 8+2k (source 0 sets bit 8, source 1 sets bit 10) one cycle after it is sampled high. The flags read at offset 0x230, and all other bits of that register read 0.
- R8: A write to offset 0x230 clears every flag written as 1. A flag whose sub-bus source is still high sets again on the following cycle.
- R9: While any sub-bus flag is set, primary line 1 is treated as asserted, so status bit 1 is set one cycle after the flag.
- R10: Writes to any other offset change no register, and reads of any other offset return 0.
- R11: A flag reads 0 one cycle after its sub-bus source is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 12 | Register offset for the write and the read view |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data of the register selected by `addr` |
| src | input | 16 | Level inputs of the primary sources |
| sub_src | input | 2 | Level inputs of the sub-bus sources |
| irq | output | 1 | CPU interrupt request |

## Verification
Two functions can act on the same bit in one cycle: a clearing write to a status bit or a flag, and a source that is still held high on that bit. The bench produces this overlap on purpose, by holding a primary source and the sub-bus sources high across clearing writes. It expects the bit to read 0 for one cycle and then 1 again. A long random phase mixes writes to every offset with changing source levels, so that the same overlap also arises together with enable toggles and the cascade. A behavioural model compares `rdata` and `irq` against the design on every clock.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_SUBFLG = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OFS_STAT = 12'h000,
  parameter int OFS_EN   = 12'h010,
  parameter int OFS_SUB  = 12'h230
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              stat_clr_en,
  output logic              en_tgl_en,
  output logic              sub_clr_en
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(OFS_SUB);

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_STAT)     sel = SEL_STATUS;
    else if (addr == A_EN)  sel = SEL_ENABLE;
    else if (addr == A_SUB) sel = SEL_SUBFLG;
  end

  assign stat_clr_en = wr_en && (sel == SEL_STATUS);
  assign en_tgl_en   = wr_en && (sel == SEL_ENABLE);
  assign sub_clr_en  = wr_en && (sel == SEL_SUBFLG);
endmodule

// File: rtl/irq_sub_flags.sv
module irq_sub_flags #(
  parameter int W        = 16,
  parameter int N_SUB    = 2,
  parameter int BASE_BIT = 8,
  parameter int STRIDE   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SUB-1:0] sub_src,
  input  logic [W-1:0]     clr,
  output logic [W-1:0]     flags,
  output logic             any
);
  logic [W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_SUB; k++) set_vec[BASE_BIT + STRIDE*k] = sub_src[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_vec & ~clr;
  end

  assign any = |flags;

  for (genvar k = 0; k < N_SUB; k++) begin : g_chk
    localparam int P = BASE_BIT + STRIDE*k;
    AST_SUB_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_src[k] && !clr[P]) |=> flags[P]);  // R7
    AST_SUB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr[P] |=> !flags[P]);  // R8
    AST_SUB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_src[k] |=> !flags[P]);  // R11
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] clr,
  input  logic         en_tgl,
  input  logic [W-1:0] en_bits,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= lines & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enable <= '0;
    else if (en_tgl) enable <= enable ^ en_bits;
  end

  assign irq = |(status & enable);

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !status[i]);  // R3
    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (lines[i] && !clr[i]) |=> status[i]);  // R2
    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !lines[i] |=> !status[i]);  // R2
  end

  AST_EN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_tgl |=> (enable == ($past(enable) ^ $past(en_bits))));  // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_tgl |=> $stable(enable));  // R5
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC    = 16,
  parameter int ADDR_W   = 12,
  parameter int N_SUB    = 2,
  parameter int SUB_BASE = 8,
  parameter int SUB_STEP = 2,
  parameter int CASC_LN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  input  logic [N_SRC-1:0]  src,
  input  logic [N_SUB-1:0]  sub_src,
  output logic              irq
);
  localparam logic [N_SRC-1:0] CASC_BIT = N_SRC'(1) << CASC_LN;

  reg_sel_t         sel;
  logic             stat_clr_en, en_tgl_en, sub_clr_en;
  logic [N_SRC-1:0] stat_clr, sub_clr, lines;
  logic [N_SRC-1:0] status, enable, flags;
  logic             sub_any;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .addr(addr), .sel(sel),
    .stat_clr_en(stat_clr_en), .en_tgl_en(en_tgl_en), .sub_clr_en(sub_clr_en)
  );

  assign stat_clr = stat_clr_en ? wdata : '0;
  assign sub_clr  = sub_clr_en  ? wdata : '0;

  irq_sub_flags #(.W(N_SRC), .N_SUB(N_SUB), .BASE_BIT(SUB_BASE), .STRIDE(SUB_STEP)) u_sub (
    .clk(clk), .rst_n(rst_n), .sub_src(sub_src), .clr(sub_clr),
    .flags(flags), .any(sub_any)
  );

  assign lines = src | (sub_any ? CASC_BIT : '0);

  irq_status_bank #(.W(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .lines(lines), .clr(stat_clr),
    .en_tgl(en_tgl_en), .en_bits(wdata),
    .status(status), .enable(enable), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: rdata = status;
      SEL_ENABLE: rdata = enable;
      SEL_SUBFLG: rdata = flags;
      default:    rdata = '0;
    endcase
  end

  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_any && !stat_clr[CASC_LN]) |=> status[CASC_LN]);  // R9
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (rdata == '0));  // R10
endmodule

// File: tb/irq_hub_test.sv
`timescale 1ns/100ps
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] src = '0;
  logic [1:0]  sub_src = '0;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  // reference state
  logic [15:0] m_stat = '0, m_en = '0, m_flg = '0;

  always #2.5 clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src(src), .sub_src(sub_src), .irq(irq)
  );

  always @(posedge clk) begin
    logic [15:0] cs, cf, ln, fs;
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_flg = '0;
    end else begin
      cs = (wr_en && addr == 12'h000) ? wdata : 16'h0;
      cf = (wr_en && addr == 12'h230) ? wdata : 16'h0;
      ln = src;
      if (m_flg != 0) ln[1] = 1'b1;
      fs = '0;
      fs[8]  = sub_src[0];
      fs[10] = sub_src[1];
      if (wr_en && addr == 12'h010) m_en = m_en ^ wdata;
      m_stat = ln & ~cs;
      m_flg  = fs & ~cf;
    end
  end

  function automatic logic [15:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return m_stat;
      12'h010: return m_en;
      12'h230: return m_flg;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the edges
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk("R6 model irq", {15'h0, irq}, {15'h0, |(m_stat & m_en)});
      chk("R10 model rdata", rdata, m_read(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, logic [15:0] e, string tag);
    addr = a;
    #0.5;
    chk(tag, rdata, e);
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h000, 16'h0000, "R1 status");
    rd(12'h010, 16'h0000, "R1 enable");
    rd(12'h230, 16'h0000, "R1 flags");
    chk("R1 irq", {15'h0, irq}, 16'h0);
    // R2 set from sources
    src = 16'h0081; step();
    rd(12'h000, 16'h0081, "R2 set");
    chk("R6 masked off", {15'h0, irq}, 16'h0);
    // R5 toggle enable
    wr(12'h010, 16'h0080);
    rd(12'h010, 16'h0080, "R5 toggle on");
    chk("R6 irq on", {15'h0, irq}, 16'h1);
    wr(12'h010, 16'h00C0);
    rd(12'h010, 16'h0040, "R5 toggle both");
    chk("R6 irq off", {15'h0, irq}, 16'h0);
    // R2 drop
    src = 16'h0040; step();
    rd(12'h000, 16'h0040, "R2 drop");
    chk("R6 irq bit6", {15'h0, irq}, 16'h1);
    // R4 clear while source held
    wr(12'h000, 16'h0040);
    rd(12'h000, 16'h0000, "R4 cleared");
    chk("R4 irq low", {15'h0, irq}, 16'h0);
    step();
    rd(12'h000, 16'h0040, "R4 reset again");
    // R3 selective clear
    src = 16'h0003; step();
    wr(12'h000, 16'h0001);
    rd(12'h000, 16'h0002, "R3 selective");
    rd(12'h000, 16'h0002, "R3 read no effect");
    src = 16'h0000; step(); step();
    rd(12'h000, 16'h0000, "R2 all low");
    // R7 / R9 sub-bus and cascade
    sub_src = 2'b01; step();
    rd(12'h230, 16'h0100, "R7 src0 bit8");
    rd(12'h000, 16'h0000, "R9 lag");
    step();
    rd(12'h000, 16'h0002, "R9 cascade");
    sub_src = 2'b11; step();
    rd(12'h230, 16'h0500, "R7 both bits");
    // R8 clear with source held
    wr(12'h230, 16'h0100);
    rd(12'h230, 16'h0400, "R8 cleared");
    step();
    rd(12'h230, 16'h0500, "R8 set again");
    wr(12'h010, 16'h0002);
    rd(12'h010, 16'h0042, "R5 add bit1");
    chk("R9 irq via cascade", {15'h0, irq}, 16'h1);
    // R11 drop
    sub_src = 2'b00; step();
    rd(12'h230, 16'h0000, "R11 flags drop");
    step();
    rd(12'h000, 16'h0000, "R9 cascade drop");
    chk("R6 irq cleared", {15'h0, irq}, 16'h0);
    // R10 unmapped
    wr(12'h020, 16'hFFFF);
    rd(12'h020, 16'h0000, "R10 read unmapped");
    rd(12'h010, 16'h0042, "R10 enable kept");
    wr(12'h231, 16'hFFFF);
    rd(12'h010, 16'h0042, "R10 enable kept2");
    // random mix checked by the model
    for (int n = 0; n < 2000; n++) begin
      logic [1:0] pick;
      pick = 2'($urandom_range(0, 3));
      case (pick)
        2'd0: addr = 12'h000;
        2'd1: addr = 12'h010;
        2'd2: addr = 12'h230;
        default: addr = 12'h020;
      endcase
      wr_en = ($urandom_range(0, 2) == 0);
      wdata = 16'($urandom);
      if ($urandom_range(0, 3) == 0) src = 16'($urandom);
      if ($urandom_range(0, 3) == 0) sub_src = 2'($urandom);
      step();
    end
    wr_en = 1'b0;
    step();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule